// File: doc/BRIEF.md
# Linked-Descriptor DMA Walker

This block moves 32-bit words between a card-side data FIFO and system memory under the control of a linked list of four-word descriptors stored in that same memory. Software builds the list, gives the engine ownership of each entry, programs the first entry's address, and pulses start. The engine reads one entry, checks that it owns it, and moves the entry's one or two buffers word by word. It then writes the control word back with ownership removed and moves on to the next entry, stopping at the entry marked last.

A single request/acknowledge memory port carries descriptor reads, descriptor write-back and data words. A one-cycle interrupt pulse reports each finished entry, unless the entry asks for silence and is not the last one. Sticky flags report a finished transfer and a stop on an entry the engine does not own. A soft-reset input aborts everything for a fixed number of cycles and then leaves the engine idle.

States: `S_IDLE`, `S_RESET`, `S_FETCH`, `S_CHECK`, `S_PULL`, `S_PUSH`, `S_BUFSW`, `S_WBACK`, `S_NEXT`, `S_STALL`. Transitions:
- soft reset from any state goes to `S_RESET`, and a finished count goes to `S_IDLE`
- start from idle goes to `S_FETCH`, and four acknowledged reads go to `S_CHECK`
- `S_CHECK` goes to `S_STALL` when the engine does not own the entry, to `S_PULL` when buffer 1 is non-empty, and otherwise to `S_BUFSW`
- a word taken from the source goes from `S_PULL` to `S_PUSH`
- a word delivered to the destination goes from `S_PUSH` back to `S_PULL`, or to `S_BUFSW` after the buffer's last word
- `S_BUFSW` goes to `S_PULL` for a second buffer, and otherwise to `S_WBACK`
- an acknowledged write-back goes to `S_NEXT`
- `S_NEXT` goes to `S_IDLE` on the last entry, and otherwise to `S_FETCH`
- start from `S_STALL` goes to `S_FETCH` and reads the same entry again

Top module: `dwalk_top`

## Requirements
- R1: After reset, busy_o, soft_rst_busy_o, xfer_done_o, desc_unavail_o, irq_pulse_o, mem_req_o, fifo_rd_o and fifo_wr_o are all low.
- R2: On start, the engine reads the four words of the entry at base_addr_i (control, sizes, buffer address, link, at byte offsets 0, 4, 8 and 12). With dir_tx_i low it pops buffer-1 words (size in bits 12:0 of word 1, a byte count that is a multiple of 4) from the FIFO and writes them in order to consecutive addresses starting at word 2.
- R3: With dir_tx_i high, the same buffer words are read from memory in address order and pushed into the FIFO in that order, and the FIFO is pushed only while it is not full.
- R4: With control bit 4 set, the next entry's address is word 3. With bit 4 clear, word 3 is the address of a second buffer, whose size is in bits 25:13 of word 1 and which is moved after buffer 1. The next entry then lies 16 bytes on, or at the base address when control bit 5 is set.
- R5: After an entry's buffers are moved, word 0 is written back before any further fetch, with bit 31 cleared and all other bits kept. Bit 30 is set when card_err_i was high while that entry's data was moving.
- R6: A fetched entry with bit 31 clear stops the engine with no data moved and sets desc_unavail_o. That flag stays set until a one-cycle pulse on clr_unavail_i, and start_i while stopped fetches the same entry again.
- R7: An entry with control bit 2 set ends the walk. xfer_done_o is then set if the byte total loaded from total_bytes_i at start, decremented by 4 per word and held at zero, has reached zero; otherwise the engine goes idle with xfer_done_o low.
- R8: irq_pulse_o is high for one cycle after each entry's write-back, except for entries with control bit 1 set that are not last.
- R9: A pulse on soft_rst_i aborts any walk and clears both flags. soft_rst_busy_o stays high for RST_CYCLES cycles with no memory or FIFO activity, and the engine is then idle.
- R10: A buffer of size zero causes no memory or FIFO data access, and the entry is still written back.
- R11: A memory request keeps its address, write enable and write data unchanged until it is acknowledged, for any acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk from idle, or retry the current entry when stalled |
| soft_rst_i | input | 1 | Soft reset request pulse |
| base_addr_i | input | AW | Byte address of the first entry |
| total_bytes_i | input | CNT_W | Total bytes expected for the walk |
| dir_tx_i | input | 1 | 0: FIFO to memory, 1: memory to FIFO |
| clr_unavail_i | input | 1 | Write-one-to-clear for the unavailable flag |
| card_err_i | input | 1 | Card-side error indication |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge (read data valid) |
| mem_rdata_i | input | 32 | Memory read data |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| fifo_rd_o | output | 1 | Receive FIFO pop, with data valid in the same cycle |
| fifo_rdata_i | input | 32 | Receive FIFO head word |
| fifo_full_i | input | 1 | Transmit FIFO full |
| fifo_wr_o | output | 1 | Transmit FIFO push |
| fifo_wdata_o | output | 32 | Transmit FIFO data |
| busy_o | output | 1 | Walk in progress |
| soft_rst_busy_o | output | 1 | Soft reset in progress (self-clearing) |
| xfer_done_o | output | 1 | Sticky transfer-complete flag |
| desc_unavail_o | output | 1 | Sticky stop-on-unowned-entry flag |
| irq_pulse_o | output | 1 | Per-entry completion pulse |

## Verification
Hand-built lists separate the link modes: a chain that jumps backwards in memory, and a ring entry with two buffers whose end-of-ring bit returns to an already-released base entry. The second case separates the next-entry rules and exercises the stop, clear and resume path. Single-entry directed cases isolate the error bit, a total that does not reach zero, a zero-size buffer and soft reset both mid-walk and while stalled. Random chains of two to five entries with random sizes (zero included), random silence bits and a random direction run against random memory latency and FIFO stalls. These separate ordering errors from handshake errors, and the interrupt count tells the silence rule apart for last and non-last entries.

// File: rtl/dwalk_pkg.sv
`timescale 1ns/1ps
package dwalk_pkg;
    // Control-word bit positions
    localparam int OWN_BIT      = 31;
    localparam int CERR_BIT     = 30;
    localparam int RING_END_BIT = 5;
    localparam int CHAIN_BIT    = 4;
    localparam int LAST_BIT     = 2;
    localparam int NOIRQ_BIT    = 1;
    // Size field geometry (bytes)
    localparam int SZ_W    = 13;
    localparam int BS1_LSB = 0;
    localparam int BS2_LSB = 13;
    localparam int WC_W    = SZ_W - 2;

    typedef enum logic [3:0] {
        S_IDLE, S_RESET, S_FETCH, S_CHECK, S_PULL,
        S_PUSH, S_BUFSW, S_WBACK, S_NEXT, S_STALL
    } dw_state_e;

    typedef struct packed {
        logic [31:0]     ctl;
        logic [WC_W-1:0] bs1_words;
        logic [WC_W-1:0] bs2_words;
    } dw_desc_t;
endpackage

// File: rtl/dwalk_word_ctr.sv
`timescale 1ns/1ps
module dwalk_word_ctr #(
    parameter int WC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            load_i,
    input  logic [WC_W-1:0] words_i,
    input  logic            dec_i,
    output logic            last_o
);
    logic [WC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= words_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - WC_W'(1);
        end
    end

    assign last_o = (cnt_q == WC_W'(1));
endmodule

// File: rtl/dwalk_link.sv
`timescale 1ns/1ps
module dwalk_link #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] link_i,
    input  logic          chain_i,
    input  logic          ring_end_i,
    output logic [AW-1:0] next_o
);
    localparam int STRIDE = 16;

    always_comb begin
        if (chain_i) begin
            next_o = link_i;
        end else if (ring_end_i) begin
            next_o = base_i;
        end else begin
            next_o = cur_i + AW'(STRIDE);
        end
    end
endmodule

// File: rtl/dwalk_flags.sv
`timescale 1ns/1ps
module dwalk_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all_i,
    input  logic clr_done_i,
    input  logic set_done_i,
    input  logic set_unavail_i,
    input  logic w1c_unavail_i,
    output logic done_o,
    output logic unavail_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            unavail_o <= 1'b0;
        end else if (clr_all_i) begin
            done_o    <= 1'b0;
            unavail_o <= 1'b0;
        end else begin
            if (set_done_i) begin
                done_o <= 1'b1;
            end else if (clr_done_i) begin
                done_o <= 1'b0;
            end
            if (set_unavail_i) begin
                unavail_o <= 1'b1;
            end else if (w1c_unavail_i) begin
                unavail_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dwalk_top.sv
`timescale 1ns/1ps
module dwalk_top
    import dwalk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CNT_W      = 24,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             soft_rst_i,
    input  logic [AW-1:0]    base_addr_i,
    input  logic [CNT_W-1:0] total_bytes_i,
    input  logic             dir_tx_i,
    input  logic             clr_unavail_i,
    input  logic             card_err_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [31:0]      mem_rdata_i,
    input  logic             fifo_empty_i,
    output logic             fifo_rd_o,
    input  logic [31:0]      fifo_rdata_i,
    input  logic             fifo_full_i,
    output logic             fifo_wr_o,
    output logic [31:0]      fifo_wdata_o,
    output logic             busy_o,
    output logic             soft_rst_busy_o,
    output logic             xfer_done_o,
    output logic             desc_unavail_o,
    output logic             irq_pulse_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    dw_state_e       state_q, state_d;
    dw_desc_t        desc_q;
    logic [AW-1:0]   cur_q, base_q, bptr_q, link_q, next_addr;
    logic [1:0]      fidx_q;
    logic            bsel_q, dir_q, cerr_q, irq_q;
    logic [31:0]     hold_q;
    logic [CNT_W-1:0] left_q;
    logic [RC_W-1:0] rcnt_q;

    logic            own, last, use_bs2, pulled, moved;
    logic            ctr_load, ctr_last;
    logic [WC_W-1:0] ctr_words;

    assign own     = desc_q.ctl[OWN_BIT];
    assign last    = desc_q.ctl[LAST_BIT];
    assign use_bs2 = !desc_q.ctl[CHAIN_BIT] && (desc_q.bs2_words != '0);
    assign pulled  = (state_q == S_PULL) && (dir_q ? mem_ack_i : !fifo_empty_i);
    assign moved   = (state_q == S_PUSH) && (dir_q ? !fifo_full_i : mem_ack_i);

    assign ctr_load  = (state_q == S_CHECK) ||
                       ((state_q == S_BUFSW) && !bsel_q && use_bs2);
    assign ctr_words = (state_q == S_CHECK) ? desc_q.bs1_words : desc_q.bs2_words;

    dwalk_word_ctr #(.WC_W(WC_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (soft_rst_i),
        .load_i  (ctr_load),
        .words_i (ctr_words),
        .dec_i   (moved),
        .last_o  (ctr_last)
    );

    dwalk_link #(.AW(AW)) u_link (
        .cur_i      (cur_q),
        .base_i     (base_q),
        .link_i     (link_q),
        .chain_i    (desc_q.ctl[CHAIN_BIT]),
        .ring_end_i (desc_q.ctl[RING_END_BIT]),
        .next_o     (next_addr)
    );

    dwalk_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_all_i     (soft_rst_i),
        .clr_done_i    ((state_q == S_IDLE) && start_i),
        .set_done_i    ((state_q == S_NEXT) && last && (left_q == '0)),
        .set_unavail_i ((state_q == S_CHECK) && !own),
        .w1c_unavail_i (clr_unavail_i),
        .done_o        (xfer_done_o),
        .unavail_o     (desc_unavail_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (soft_rst_i) begin
            state_d = S_RESET;
        end else begin
            unique case (state_q)
                S_IDLE:  if (start_i) state_d = S_FETCH;
                S_RESET: if (rcnt_q == '0) state_d = S_IDLE;
                S_FETCH: if (mem_ack_i && (fidx_q == 2'd3)) state_d = S_CHECK;
                S_CHECK: begin
                    if (!own) begin
                        state_d = S_STALL;
                    end else if (desc_q.bs1_words != '0) begin
                        state_d = S_PULL;
                    end else begin
                        state_d = S_BUFSW;
                    end
                end
                S_PULL:  if (pulled) state_d = S_PUSH;
                S_PUSH:  if (moved) state_d = ctr_last ? S_BUFSW : S_PULL;
                S_BUFSW: state_d = (!bsel_q && use_bs2) ? S_PULL : S_WBACK;
                S_WBACK: if (mem_ack_i) state_d = S_NEXT;
                S_NEXT:  state_d = last ? S_IDLE : S_FETCH;
                S_STALL: if (start_i) state_d = S_FETCH;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= '0;
            cur_q  <= '0;
            base_q <= '0;
            bptr_q <= '0;
            link_q <= '0;
            fidx_q <= '0;
            bsel_q <= 1'b0;
            dir_q  <= 1'b0;
            cerr_q <= 1'b0;
            irq_q  <= 1'b0;
            hold_q <= '0;
            left_q <= '0;
            rcnt_q <= '0;
        end else if (soft_rst_i) begin
            fidx_q <= '0;
            bsel_q <= 1'b0;
            cerr_q <= 1'b0;
            irq_q  <= 1'b0;
            rcnt_q <= RC_W'(RST_CYCLES - 1);
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        cur_q  <= base_addr_i;
                        base_q <= base_addr_i;
                        left_q <= total_bytes_i;
                        dir_q  <= dir_tx_i;
                        fidx_q <= '0;
                    end
                end
                S_RESET: begin
                    if (rcnt_q != '0) rcnt_q <= rcnt_q - RC_W'(1);
                end
                S_FETCH: begin
                    if (mem_ack_i) begin
                        unique case (fidx_q)
                            2'd0: desc_q.ctl <= mem_rdata_i;
                            2'd1: begin
                                desc_q.bs1_words <= mem_rdata_i[BS1_LSB+2 +: WC_W];
                                desc_q.bs2_words <= mem_rdata_i[BS2_LSB+2 +: WC_W];
                            end
                            2'd2: bptr_q <= mem_rdata_i[AW-1:0];
                            default: link_q <= mem_rdata_i[AW-1:0];
                        endcase
                        fidx_q <= fidx_q + 2'd1;
                    end
                end
                S_CHECK: begin
                    bsel_q <= 1'b0;
                    cerr_q <= 1'b0;
                end
                S_PULL: begin
                    if (card_err_i) cerr_q <= 1'b1;
                    if (pulled) hold_q <= dir_q ? mem_rdata_i : fifo_rdata_i;
                end
                S_PUSH: begin
                    if (card_err_i) cerr_q <= 1'b1;
                    if (moved) begin
                        bptr_q <= bptr_q + AW'(4);
                        left_q <= (left_q >= CNT_W'(4)) ? (left_q - CNT_W'(4)) : '0;
                    end
                end
                S_BUFSW: begin
                    if (card_err_i) cerr_q <= 1'b1;
                    if (!bsel_q && use_bs2) begin
                        bsel_q <= 1'b1;
                        bptr_q <= link_q;
                    end
                end
                S_WBACK: begin
                    if (mem_ack_i) irq_q <= !desc_q.ctl[NOIRQ_BIT] || last;
                end
                S_NEXT: begin
                    if (!last) begin
                        cur_q  <= next_addr;
                        fidx_q <= '0;
                    end
                end
                S_STALL: begin
                    if (start_i) fidx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_o       = 1'b0;
        mem_we_o        = 1'b0;
        mem_addr_o      = '0;
        mem_wdata_o     = '0;
        fifo_rd_o       = 1'b0;
        fifo_wr_o       = 1'b0;
        fifo_wdata_o    = hold_q;
        busy_o          = 1'b1;
        soft_rst_busy_o = 1'b0;
        unique case (state_q)
            S_IDLE, S_STALL: busy_o = 1'b0;
            S_RESET: begin
                busy_o          = 1'b0;
                soft_rst_busy_o = 1'b1;
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + AW'({fidx_q, 2'b00});
            end
            S_PULL: begin
                if (dir_q) begin
                    mem_req_o  = 1'b1;
                    mem_addr_o = bptr_q;
                end else begin
                    fifo_rd_o = !fifo_empty_i;
                end
            end
            S_PUSH: begin
                if (dir_q) begin
                    fifo_wr_o = !fifo_full_i;
                end else begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = bptr_q;
                    mem_wdata_o = hold_q;
                end
            end
            S_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cur_q;
                mem_wdata_o = {1'b0, desc_q.ctl[CERR_BIT] | cerr_q, desc_q.ctl[29:0]};
            end
            S_CHECK, S_BUFSW, S_NEXT: ;
            default: busy_o = 1'b0;
        endcase
    end

    assign irq_pulse_o = irq_q;
endmodule

// File: rtl/dwalk_top_chk.sv
`timescale 1ns/1ps
module dwalk_top_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_ack_i,
    input logic          fifo_empty_i,
    input logic          fifo_rd_o,
    input logic          fifo_full_i,
    input logic          fifo_wr_o,
    input logic          busy_o,
    input logic          soft_rst_busy_o,
    input logic          xfer_done_o,
    input logic          desc_unavail_o,
    input logic          irq_pulse_o
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !soft_rst_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    p_rst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_busy_o |-> (!mem_req_o && !fifo_rd_o && !fifo_wr_o && !busy_o));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |=> !irq_pulse_o);

    p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_unavail_o) |-> (!mem_req_o && !busy_o));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done_o) |-> !busy_o);

    p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> !fifo_full_i);
endmodule

bind dwalk_top dwalk_top_chk #(.AW(AW)) u_chk (.*);

// File: tb/dwalk_top_bench.sv
`timescale 1ns/1ps
module dwalk_top_bench;
    localparam logic [31:0] OWN = 32'h8000_0000, CE = 32'h4000_0000, ER = 32'h20,
                            CH = 32'h10, FS = 32'h8, LD = 32'h4, DIC = 32'h2;
    localparam int RSTC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start_i, soft_rst_i, dir_tx_i, clr_unavail_i, card_err_i;
    logic [31:0] base_addr_i;
    logic [23:0] total_bytes_i;
    logic mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic fifo_empty_i, fifo_rd_o, fifo_full_i, fifo_wr_o;
    logic [31:0] fifo_rdata_i, fifo_wdata_o;
    logic busy_o, soft_rst_busy_o, xfer_done_o, desc_unavail_o, irq_pulse_o;

    dwalk_top #(.AW(32), .CNT_W(24), .RST_CYCLES(RSTC)) u_dwalk_top (.*);

    logic [31:0] mem [0:1023];
    logic [31:0] txlog [0:1023];
    int tx_n = 0, irq_n = 0, lat = 0;
    logic [31:0] rx_seq = 32'h1000;
    bit stall_en = 1'b0;
    int checks = 0, fails = 0;

    assign fifo_rdata_i = rx_seq;

    // Memory, FIFO and interrupt models
    always @(posedge clk) begin
        mem_ack_i <= 1'b0;
        if (mem_req_o && !mem_ack_i) begin
            if (lat == 0) begin
                mem_ack_i <= 1'b1;
                if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
                else mem_rdata_i <= mem[mem_addr_o[11:2]];
                lat <= stall_en ? int'($urandom % 3) : 0;
            end else begin
                lat <= lat - 1;
            end
        end
        if (fifo_rd_o) rx_seq <= rx_seq + 1;
        if (fifo_wr_o) begin
            txlog[tx_n[9:0]] <= fifo_wdata_o;
            tx_n <= tx_n + 1;
        end
        if (irq_pulse_o) irq_n <= irq_n + 1;
        fifo_empty_i <= stall_en && ($urandom % 4 == 0);
        fifo_full_i  <= stall_en && ($urandom % 4 == 0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] v);
        mem[a[11:2]] <= v;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        wr(a, w0); wr(a + 4, w1); wr(a + 8, w2); wr(a + 12, w3);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    task automatic run(input logic [31:0] base, input int total, input bit dir);
        @(negedge clk);
        base_addr_i   = base;
        total_bytes_i = 24'(total);
        dir_tx_i      = dir;
        pulse_start();
    endtask

    function automatic logic [31:0] mw(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    function automatic int irq_expect(input int n, input bit dic_a [8]);
        int e = 0;
        for (int k = 0; k < n; k++) if (!dic_a[k] || (k == n - 1)) e++;
        return e;
    endfunction

    task automatic rand_round();
        int n, tot, cum, irq0, tx0, bad;
        int sz [8];
        bit dic_a [8];
        logic [31:0] seq0;
        logic [31:0] expd [64];
        bit dir;
        n = 2 + int'($urandom % 4);
        dir = 1'($urandom % 2);
        tot = 0;
        cum = 0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] sa, ba, ctl;
            sz[k] = int'($urandom % 7);
            dic_a[k] = 1'($urandom % 2);
            sa = 32'h300 + 32'((n - 1 - k) * 16);
            ba = 32'hB00 + 32'(k * 64);
            ctl = OWN | (dic_a[k] ? DIC : 0) | ((k == n - 1) ? LD : CH) | ((k == 0) ? FS : 0);
            put_desc(sa, ctl, 32'(sz[k] * 4), ba,
                     (k == n - 1) ? 32'h0 : 32'h300 + 32'((n - 2 - k) * 16));
            for (int w = 0; w < sz[k]; w++) begin
                expd[cum] = $urandom;
                wr(ba + 32'(w * 4), dir ? expd[cum] : 32'h0);
                cum++;
            end
            tot += sz[k] * 4;
        end
        @(negedge clk);
        irq0 = irq_n;
        tx0 = tx_n;
        seq0 = rx_seq;
        run(32'h300 + 32'((n - 1) * 16), tot, dir);
        bad = 0;
        cum = 0;
        for (int k = 0; k < n; k++) begin
            for (int w = 0; w < sz[k]; w++) begin
                logic [31:0] act, ex;
                if (dir) begin
                    act = txlog[10'(tx0 + cum)];
                    ex = expd[cum];
                end else begin
                    act = mw(32'hB00 + 32'(k * 64 + w * 4));
                    ex = seq0 + 32'(cum);
                end
                if (act != ex && bad == 0) begin
                    bad = 1;
                    chk(0, dir ? "R3" : "R2", "random data word", act, ex);
                end
                cum++;
            end
            if (mw(32'h300 + 32'((n - 1 - k) * 16)) & OWN) bad = bad + 2;
        end
        chk(bad == 0, "R11", "random walk data and ownership", bad, 0);
        chk((dir ? tx_n - tx0 : int'(rx_seq - seq0)) == cum, dir ? "R3" : "R2",
            "random word count", dir ? tx_n - tx0 : int'(rx_seq - seq0), cum);
        chk(irq_n - irq0 == irq_expect(n, dic_a), "R8", "random irq count",
            irq_n - irq0, irq_expect(n, dic_a));
        chk(xfer_done_o == 1'b1, "R7", "random done", xfer_done_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int irq0, tx0;
        logic [31:0] seq0;
        void'($urandom(32'd2024));
        rst_n = 1'b0; start_i = 1'b0; soft_rst_i = 1'b0; dir_tx_i = 1'b0;
        clr_unavail_i = 1'b0; card_err_i = 1'b0; base_addr_i = '0; total_bytes_i = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet reset state
        chk(!busy_o && !soft_rst_busy_o && !irq_pulse_o, "R1", "busy/rst/irq", busy_o, 0);
        chk(!xfer_done_o && !desc_unavail_o, "R1", "flags", {xfer_done_o, desc_unavail_o}, 0);
        chk(!mem_req_o && !fifo_rd_o && !fifo_wr_o, "R1", "port strobes", mem_req_o, 0);

        // Chained list jumping backwards in memory, FIFO to memory
        stall_en = 1'b1;
        put_desc(32'h000, OWN | CH | FS | DIC, 32'd16, 32'h400, 32'h100);
        put_desc(32'h100, OWN | CH, 32'd12, 32'h500, 32'h020);
        put_desc(32'h020, OWN | LD | DIC, 32'd8, 32'h600, 32'h0);
        @(negedge clk);
        irq0 = irq_n; seq0 = rx_seq;
        run(32'h000, 36, 1'b0);
        chk(mw(32'h400) == seq0 && mw(32'h40C) == seq0 + 3, "R2", "buffer A words",
            mw(32'h40C), seq0 + 3);
        chk(mw(32'h500) == seq0 + 4 && mw(32'h508) == seq0 + 6, "R4", "chained buffer B",
            mw(32'h508), seq0 + 6);
        chk(mw(32'h604) == seq0 + 8, "R4", "chained buffer C", mw(32'h604), seq0 + 8);
        chk(mw(32'h000) == (CH | FS | DIC) && mw(32'h020) == (LD | DIC), "R5",
            "owner released", mw(32'h000), CH | FS | DIC);
        chk(xfer_done_o, "R7", "done after last", xfer_done_o, 1);
        chk(irq_n - irq0 == 2, "R8", "irq silence on non-last only", irq_n - irq0, 2);

        // Memory to FIFO
        put_desc(32'h0F0, OWN | LD, 32'd12, 32'h900, 32'h0);
        wr(32'h900, 32'hA1); wr(32'h904, 32'hA2); wr(32'h908, 32'hA3);
        @(negedge clk);
        tx0 = tx_n;
        run(32'h0F0, 12, 1'b1);
        chk(tx_n - tx0 == 3, "R3", "pushed count", tx_n - tx0, 3);
        chk(txlog[10'(tx0)] == 32'hA1 && txlog[10'(tx0 + 2)] == 32'hA3, "R3", "pushed order",
            txlog[10'(tx0 + 2)], 32'hA3);

        // Ring entry with two buffers, end-of-ring back to a released base
        put_desc(32'h200, OWN, 32'd8 | (32'd4 << 13), 32'h700, 32'h780);
        put_desc(32'h210, OWN | ER, 32'd4, 32'h7C0, 32'h0);
        @(negedge clk);
        irq0 = irq_n; seq0 = rx_seq;
        run(32'h200, 20, 1'b0);
        chk(mw(32'h704) == seq0 + 1 && mw(32'h780) == seq0 + 2, "R4", "second buffer",
            mw(32'h780), seq0 + 2);
        chk(mw(32'h7C0) == seq0 + 3, "R4", "next at +16", mw(32'h7C0), seq0 + 3);
        chk(desc_unavail_o && !busy_o && !xfer_done_o, "R6", "stall on base",
            desc_unavail_o, 1);
        chk(rx_seq - seq0 == 4, "R6", "no data on unowned entry", rx_seq - seq0, 4);
        chk(irq_n - irq0 == 2, "R8", "irq for two entries", irq_n - irq0, 2);
        @(negedge clk); clr_unavail_i = 1'b1;
        @(negedge clk); clr_unavail_i = 1'b0;
        chk(!desc_unavail_o, "R6", "w1c clear", desc_unavail_o, 0);
        put_desc(32'h200, OWN | LD, 32'd4, 32'h7E0, 32'h0);
        @(negedge clk);
        pulse_start();
        chk(mw(32'h7E0) == seq0 + 4, "R6", "resume refetch", mw(32'h7E0), seq0 + 4);
        chk(xfer_done_o, "R7", "done after resume", xfer_done_o, 1);

        // Card error during data
        put_desc(32'h0E0, OWN | LD, 32'd8, 32'hA00, 32'h0);
        @(negedge clk);
        card_err_i = 1'b1;
        run(32'h0E0, 8, 1'b0);
        card_err_i = 1'b0;
        chk(mw(32'h0E0) == (LD | CE), "R5", "error summary bit", mw(32'h0E0), LD | CE);

        // Total not exhausted
        put_desc(32'h0D0, OWN | LD, 32'd8, 32'hA40, 32'h0);
        @(negedge clk);
        run(32'h0D0, 64, 1'b0);
        chk(!xfer_done_o && !busy_o, "R7", "no done with bytes left", xfer_done_o, 0);

        // Zero-size buffer
        put_desc(32'h0C0, OWN | LD | DIC, 32'd0, 32'hA80, 32'h0);
        wr(32'hA80, 32'hDEADBEEF);
        @(negedge clk);
        irq0 = irq_n; seq0 = rx_seq;
        run(32'h0C0, 0, 1'b0);
        chk(rx_seq == seq0 && mw(32'hA80) == 32'hDEADBEEF, "R10", "no data access",
            mw(32'hA80), 32'hDEADBEEF);
        chk(mw(32'h0C0) == (LD | DIC) && irq_n - irq0 == 1, "R10", "still written back",
            mw(32'h0C0), LD | DIC);

        // Soft reset clears a stall
        put_desc(32'h0B0, LD, 32'd4, 32'hAC0, 32'h0);
        @(negedge clk);
        run(32'h0B0, 4, 1'b0);
        chk(desc_unavail_o, "R6", "unowned single entry", desc_unavail_o, 1);
        soft_rst_i = 1'b1;
        @(negedge clk); soft_rst_i = 1'b0;
        chk(soft_rst_busy_o && !desc_unavail_o, "R9", "reset clears stall flag",
            desc_unavail_o, 0);
        repeat (RSTC) @(negedge clk);

        // Soft reset in the middle of a walk
        put_desc(32'h0A0, OWN | LD, 32'd64, 32'hC80, 32'h0);
        @(negedge clk);
        base_addr_i = 32'h0A0; total_bytes_i = 24'd64; dir_tx_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (12) @(negedge clk);
        soft_rst_i = 1'b1;
        @(negedge clk); soft_rst_i = 1'b0;
        chk(soft_rst_busy_o && !mem_req_o && !busy_o, "R9", "reset in progress",
            soft_rst_busy_o, 1);
        repeat (RSTC - 2) @(negedge clk);
        chk(soft_rst_busy_o, "R9", "reset length", soft_rst_busy_o, 1);
        repeat (2) @(negedge clk);
        chk(!soft_rst_busy_o && !busy_o && !xfer_done_o, "R9", "idle after reset",
            soft_rst_busy_o, 0);

        // Random chains
        for (int r = 0; r < 10; r++) rand_round();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule